// File: doc/BRIEF.md
# Hardware Exception Entry Unit

This unit computes the architectural state that a small 32-bit soft processor takes on when it accepts a hardware exception. Each cycle it samples the current program counter, link register, exception status, branch-target save register, machine status word and instruction flags. It also samples the pending branch target, an exception request and a configuration enable. One clock later it presents the next value of every one of these registers.

When no exception is accepted, the outputs are simply the sampled values. When an exception is accepted, the unit saves the return address and notes whether a branch delay slot was cut short, keeping that branch's target if so. It pushes the translation and user-mode bits into their saved copies, marks an exception as in progress, clears the prefix and delay-slot flags and sends the PC to a fixed vector. A one-cycle `entry_done` pulse accompanies the updated values so that surrounding control can write them back.

Top module: `exc_entry_unit`

## Requirements
- R1: When `exc_req` is high while `cfg_exc_en` is low, `entry_done` stays low one cycle later and every next-state output equals the corresponding input of the request cycle.
- R2: On an accepted entry, `nxt_r17` equals the sampled `cur_pc` plus 4.
- R3: On an accepted entry, `nxt_esr` bit 12 equals the delay-slot flag (`cur_iflags` bit 1), and every other ESR bit is copied unchanged.
- R4: On an accepted entry, `nxt_btr` takes `br_target` if the delay-slot flag is set and keeps `cur_btr` otherwise.
- R5: On an accepted entry, MSR bit 13 (translation) is copied to bit 14 and bit 11 (user mode) is copied to bit 12, after which bits 13 and 11 are cleared. MSR bits other than 9, 11, 12, 13 and 14 are unchanged.
- R6: On an accepted entry, MSR bit 9 (exception in progress) is set.
- R7: On an accepted entry, `nxt_iflags` bits 0 (immediate prefix) and 1 (delay slot) are cleared, and the remaining flag bits are unchanged.
- R8: On an accepted entry, `nxt_pc` equals 0x20.
- R9: The outputs of an accepted entry appear, together with a single-cycle `entry_done`, in the cycle after the request edge. Without a request, outputs equal the previous cycle's inputs and `entry_done` is low.
- R10: A request that arrives while MSR bit 9 is already set performs the full entry sequence.
- R11: While reset is asserted, all outputs are zero and `entry_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 1 | Hardware exception request |
| cfg_exc_en | input | 1 | Configuration: exceptions supported |
| cur_pc | input | 32 | Current program counter |
| cur_r17 | input | 32 | Current link register |
| cur_esr | input | 32 | Current exception status register |
| cur_btr | input | 32 | Current branch-target save register |
| cur_msr | input | 32 | Current machine status register |
| cur_iflags | input | 4 | Current instruction flags |
| br_target | input | 32 | Pending branch target |
| nxt_pc | output | 32 | Next program counter |
| nxt_r17 | output | 32 | Next link register |
| nxt_esr | output | 32 | Next exception status register |
| nxt_btr | output | 32 | Next branch-target save register |
| nxt_msr | output | 32 | Next machine status register |
| nxt_iflags | output | 4 | Next instruction flags |
| entry_done | output | 1 | Entry applied this cycle |

## Verification
The entry is exercised with random register contents under four flag patterns: delay slot set or clear, crossed with exception-in-progress set or clear. Comparing the delay-slot cases shows whether BTR and ESR bit 12 follow the flag. The exception-in-progress cases show whether nesting is wrongly blocked. Directed MSR words with only the translation bit set, or only the user-mode bit set, show whether each bit lands in its own saved copy rather than the other's. Requests with the enable low, and idle cycles, are compared against plain pass-through to separate "no entry" from "entry with wrong values".

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN = 32;
    localparam int IFW  = 4;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] r17;
        logic [XLEN-1:0] esr;
        logic [XLEN-1:0] btr;
        logic [XLEN-1:0] msr;
        logic [IFW-1:0]  iflags;
        logic            done;
    } exc_state_t;

endpackage

// File: rtl/exc_msr_stack.sv
module exc_msr_stack #(
    parameter int W           = 32,
    parameter int MSR_VM_BIT  = 13,
    parameter int MSR_UM_BIT  = 11,
    parameter int MSR_EIP_BIT = 9
) (
    input  logic [W-1:0] msr_in,
    output logic [W-1:0] msr_out
);
    localparam int VMS_BIT = MSR_VM_BIT + 1;
    localparam int UMS_BIT = MSR_UM_BIT + 1;
    localparam logic [W-1:0] LIVE_MASK  = (W'(1) << MSR_VM_BIT) | (W'(1) << MSR_UM_BIT);
    localparam logic [W-1:0] SAVE_MASK  = (W'(1) << VMS_BIT) | (W'(1) << UMS_BIT);
    localparam logic [W-1:0] EIP_MASK   = W'(1) << MSR_EIP_BIT;

    logic [W-1:0] pushed;

    always_comb begin
        pushed  = (msr_in & LIVE_MASK) << 1;
        msr_out = (msr_in & ~(LIVE_MASK | SAVE_MASK)) | pushed | EIP_MASK;
    end
endmodule

// File: rtl/exc_ctx_save.sv
module exc_ctx_save #(
    parameter int W          = 32,
    parameter int ESR_DS_BIT = 12,
    parameter int PC_STEP    = 4
) (
    input  logic [W-1:0] pc_in,
    input  logic         dslot,
    input  logic [W-1:0] esr_in,
    input  logic [W-1:0] btr_in,
    input  logic [W-1:0] target,
    output logic [W-1:0] r17_out,
    output logic [W-1:0] esr_out,
    output logic [W-1:0] btr_out
);
    localparam logic [W-1:0] DS_MASK = W'(1) << ESR_DS_BIT;

    always_comb begin
        r17_out = pc_in + W'(PC_STEP);
        esr_out = esr_in & ~DS_MASK;
        btr_out = btr_in;
        if (dslot) begin
            esr_out = esr_out | DS_MASK;
            btr_out = target;
        end
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int              MSR_VM_BIT   = 13,
    parameter int              MSR_UM_BIT   = 11,
    parameter int              MSR_EIP_BIT  = 9,
    parameter int              ESR_DS_BIT   = 12,
    parameter int              IF_IMM_BIT   = 0,
    parameter int              IF_DSLOT_BIT = 1,
    parameter int              PC_STEP      = 4,
    parameter logic [XLEN-1:0] EXC_VECTOR   = 32'h0000_0020
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_req,
    input  logic            cfg_exc_en,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_r17,
    input  logic [XLEN-1:0] cur_esr,
    input  logic [XLEN-1:0] cur_btr,
    input  logic [XLEN-1:0] cur_msr,
    input  logic [IFW-1:0]  cur_iflags,
    input  logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] nxt_pc,
    output logic [XLEN-1:0] nxt_r17,
    output logic [XLEN-1:0] nxt_esr,
    output logic [XLEN-1:0] nxt_btr,
    output logic [XLEN-1:0] nxt_msr,
    output logic [IFW-1:0]  nxt_iflags,
    output logic            entry_done
);
    localparam logic [IFW-1:0] IF_CLR_MASK =
        (IFW'(1) << IF_IMM_BIT) | (IFW'(1) << IF_DSLOT_BIT);

    exc_state_t state_d, state_q;
    logic            take;
    logic            dslot;
    logic [XLEN-1:0] stk_msr, sv_r17, sv_esr, sv_btr;

    assign take  = exc_req && cfg_exc_en;
    assign dslot = cur_iflags[IF_DSLOT_BIT];

    exc_msr_stack #(
        .W(XLEN), .MSR_VM_BIT(MSR_VM_BIT),
        .MSR_UM_BIT(MSR_UM_BIT), .MSR_EIP_BIT(MSR_EIP_BIT)
    ) u_msr (
        .msr_in (cur_msr),
        .msr_out(stk_msr)
    );

    exc_ctx_save #(
        .W(XLEN), .ESR_DS_BIT(ESR_DS_BIT), .PC_STEP(PC_STEP)
    ) u_ctx (
        .pc_in  (cur_pc),
        .dslot  (dslot),
        .esr_in (cur_esr),
        .btr_in (cur_btr),
        .target (br_target),
        .r17_out(sv_r17),
        .esr_out(sv_esr),
        .btr_out(sv_btr)
    );

    always_comb begin
        state_d.pc     = cur_pc;
        state_d.r17    = cur_r17;
        state_d.esr    = cur_esr;
        state_d.btr    = cur_btr;
        state_d.msr    = cur_msr;
        state_d.iflags = cur_iflags;
        state_d.done   = 1'b0;
        if (take) begin
            state_d.pc     = EXC_VECTOR;
            state_d.r17    = sv_r17;
            state_d.esr    = sv_esr;
            state_d.btr    = sv_btr;
            state_d.msr    = stk_msr;
            state_d.iflags = cur_iflags & ~IF_CLR_MASK;
            state_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign nxt_pc     = state_q.pc;
    assign nxt_r17    = state_q.r17;
    assign nxt_esr    = state_q.esr;
    assign nxt_btr    = state_q.btr;
    assign nxt_msr    = state_q.msr;
    assign nxt_iflags = state_q.iflags;
    assign entry_done = state_q.done;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int              MSR_VM_BIT   = 13,
    parameter int              MSR_UM_BIT   = 11,
    parameter int              MSR_EIP_BIT  = 9,
    parameter int              ESR_DS_BIT   = 12,
    parameter int              IF_IMM_BIT   = 0,
    parameter int              IF_DSLOT_BIT = 1,
    parameter int              PC_STEP      = 4,
    parameter logic [XLEN-1:0] EXC_VECTOR   = 32'h0000_0020
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_req,
    input logic            cfg_exc_en,
    input logic [XLEN-1:0] cur_pc,
    input logic [XLEN-1:0] cur_msr,
    input logic [IFW-1:0]  cur_iflags,
    input logic [XLEN-1:0] nxt_pc,
    input logic [XLEN-1:0] nxt_r17,
    input logic [XLEN-1:0] nxt_esr,
    input logic [XLEN-1:0] nxt_msr,
    input logic [IFW-1:0]  nxt_iflags,
    input logic            entry_done
);
    p_disabled_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !cfg_exc_en) |=>
        (!entry_done && nxt_pc == $past(cur_pc) && nxt_msr == $past(cur_msr)));

    p_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> nxt_r17 == $past(cur_pc) + XLEN'(PC_STEP));

    p_ds_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> nxt_esr[ESR_DS_BIT] == $past(cur_iflags[IF_DSLOT_BIT]));

    p_stack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (nxt_msr[MSR_VM_BIT+1] == $past(cur_msr[MSR_VM_BIT]) &&
                        nxt_msr[MSR_UM_BIT+1] == $past(cur_msr[MSR_UM_BIT]) &&
                        !nxt_msr[MSR_VM_BIT] && !nxt_msr[MSR_UM_BIT]));

    p_eip_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> nxt_msr[MSR_EIP_BIT]);

    p_flags_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (!nxt_iflags[IF_IMM_BIT] && !nxt_iflags[IF_DSLOT_BIT]));

    p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> nxt_pc == EXC_VECTOR);

    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> $past(exc_req && cfg_exc_en));

    p_nested_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && cfg_exc_en && cur_msr[MSR_EIP_BIT]) |=> entry_done);
endmodule

bind exc_entry_unit exc_entry_chk #(
    .MSR_VM_BIT(MSR_VM_BIT), .MSR_UM_BIT(MSR_UM_BIT), .MSR_EIP_BIT(MSR_EIP_BIT),
    .ESR_DS_BIT(ESR_DS_BIT), .IF_IMM_BIT(IF_IMM_BIT), .IF_DSLOT_BIT(IF_DSLOT_BIT),
    .PC_STEP(PC_STEP), .EXC_VECTOR(EXC_VECTOR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cfg_exc_en(cfg_exc_en),
    .cur_pc(cur_pc), .cur_msr(cur_msr), .cur_iflags(cur_iflags),
    .nxt_pc(nxt_pc), .nxt_r17(nxt_r17), .nxt_esr(nxt_esr), .nxt_msr(nxt_msr),
    .nxt_iflags(nxt_iflags), .entry_done(entry_done)
);

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/1ps
module sim_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0, cfg_exc_en = 1'b0;
    logic [31:0] cur_pc = '0, cur_r17 = '0, cur_esr = '0, cur_btr = '0, cur_msr = '0, br_target = '0;
    logic [3:0]  cur_iflags = '0;
    logic [31:0] nxt_pc, nxt_r17, nxt_esr, nxt_btr, nxt_msr;
    logic [3:0]  nxt_iflags;
    logic        entry_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    exc_entry_unit u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cfg_exc_en(cfg_exc_en),
        .cur_pc(cur_pc), .cur_r17(cur_r17), .cur_esr(cur_esr), .cur_btr(cur_btr),
        .cur_msr(cur_msr), .cur_iflags(cur_iflags), .br_target(br_target),
        .nxt_pc(nxt_pc), .nxt_r17(nxt_r17), .nxt_esr(nxt_esr), .nxt_btr(nxt_btr),
        .nxt_msr(nxt_msr), .nxt_iflags(nxt_iflags), .entry_done(entry_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_msr(input logic [31:0] m);
        logic [31:0] r;
        r = m;
        r[14] = m[13];
        r[12] = m[11];
        r[13] = 1'b0;
        r[11] = 1'b0;
        r[9]  = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] exp_esr(input logic [31:0] e, input logic ds);
        logic [31:0] r;
        r = e;
        r[12] = ds;
        return r;
    endfunction

    // Drive one cycle of inputs at a falling edge, check at the next falling edge.
    task automatic step(input logic req, input logic en);
        logic        take;
        logic [31:0] pc, r17, esr, btr, msr, tgt;
        logic [3:0]  fl;
        exc_req = req; cfg_exc_en = en;
        take = req && en;
        pc = cur_pc; r17 = cur_r17; esr = cur_esr; btr = cur_btr;
        msr = cur_msr; fl = cur_iflags; tgt = br_target;
        @(negedge clk);
        if (take) begin
            chk("R8 pc vector", nxt_pc, 32'h20);
            chk("R2 link", nxt_r17, pc + 32'd4);
            chk("R3 esr", nxt_esr, exp_esr(esr, fl[1]));
            chk("R4 btr", nxt_btr, fl[1] ? tgt : btr);
            chk("R5 R6 msr", nxt_msr, exp_msr(msr));
            chk("R7 iflags", {28'd0, nxt_iflags}, {28'd0, fl & 4'b1100});
            chk("R9 done pulse", {31'd0, entry_done}, 32'd1);
        end else begin
            chk("R1 R9 pc hold", nxt_pc, pc);
            chk("R1 R9 r17 hold", nxt_r17, r17);
            chk("R1 R9 esr hold", nxt_esr, esr);
            chk("R1 R9 btr hold", nxt_btr, btr);
            chk("R1 R9 msr hold", nxt_msr, msr);
            chk("R1 R9 iflags hold", {28'd0, nxt_iflags}, {28'd0, fl});
            chk("R1 R9 no done", {31'd0, entry_done}, 32'd0);
        end
    endtask

    task automatic load(input logic [31:0] pc, esr, btr, msr, tgt, input logic [3:0] fl);
        cur_pc = pc; cur_r17 = $urandom; cur_esr = esr; cur_btr = btr;
        cur_msr = msr; br_target = tgt; cur_iflags = fl;
    endtask

    initial begin
        void'($urandom(32'd2024));
        cur_pc = 32'hDEAD_BEEF; cur_msr = 32'hFFFF_FFFF; exc_req = 1'b1; cfg_exc_en = 1'b1;
        #35;
        chk("R11 reset pc", nxt_pc, 32'd0);
        chk("R11 reset msr", nxt_msr, 32'd0);
        chk("R11 reset done", {31'd0, entry_done}, 32'd0);
        exc_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corner cases
        load(32'h0000_1000, 32'h0000_0000, 32'h1111_1111, 32'h0000_2000, 32'h0000_4444, 4'b0011);
        step(1'b1, 1'b1);                  // R5: only translation bit set, delay slot
        load(32'h0000_2000, 32'hFFFF_FFFF, 32'h2222_2222, 32'h0000_0800, 32'h0000_5555, 4'b1101);
        step(1'b1, 1'b1);                  // R5: only user-mode bit; R3 clears bit 12
        load(32'h0000_3000, 32'h0000_1000, 32'h3333_3333, 32'h0000_0200, 32'h0000_6666, 4'b0010);
        step(1'b1, 1'b1);                  // R10: exception already in progress
        load(32'hFFFF_FFFC, 32'h1234_5678, 32'h4444_4444, 32'hFFFF_FFFF, 32'h0000_7777, 4'b1111);
        step(1'b1, 1'b1);                  // R2 wrap, all MSR bits set
        load(32'h0000_5000, 32'h0, 32'h5555_5555, 32'h0000_2800, 32'h0000_8888, 4'b0010);
        step(1'b1, 1'b0);                  // R1: disabled request
        step(1'b0, 1'b1);                  // R9: idle pass-through

        // Constrained random
        for (int i = 0; i < 300; i++) begin
            load($urandom & 32'hFFFF_FFFC, $urandom, $urandom, $urandom, $urandom & 32'hFFFF_FFFC,
                 4'($urandom));
            step(($urandom % 4) != 0, ($urandom % 5) != 0);
        end
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule